// File: doc/BRIEF.md
# Overrange Fault Qualifier with Blanking

This block watches a stream of signed current samples and decides when a short circuit is real. Each valid sample is compared in magnitude against a threshold, so excursions in either polarity count. A lone spike or a short run of overrange samples is rejected. Only an overrange that persists for a programmed number of clock cycles trips the fault. Once tripped, the fault is held until the input has stayed back in range for a longer, separate release time.

The output is an enable for an open-drain pull-down. Several phase instances can therefore drive one shared fault line, which reads low whenever any instance pulls it. When the input side reports that it is not alive, the pull-down is released at once and the qualifier forgets its history. The block sits beside the measurement path and does not depend on it.

All times are parameters in clock cycles. An elaboration check rejects a configuration whose rejection time exceeds its detect time.

Top module: `ovr_fault_qual`

## Requirements
- R1: A captured sample is overrange when its two's-complement magnitude is strictly greater than `thr_mag`, for positive and negative samples alike. A magnitude equal to the threshold is in range. The most negative code has magnitude 2^(SAMPLE_W-1).
- R2: The overrange flag is updated only on cycles with `smp_vld` high. Between strobes it keeps the value of the last captured sample.
- R3: `fault_pd_en` goes high once the captured overrange flag has been high for DETECT_CYC consecutive clock edges. A pulse whose flag stays high for DETECT_CYC-1 edges does not trip. With DETECT_CYC = 750, the enable rises on the clock after the 750th such edge. `fault_pd_en` = 1 means the shared line is pulled low, which signals a fault.
- R4: Any captured in-range sample clears qualification. A burst of short overrange runs separated by single in-range samples never trips, however long the burst.
- R5: While faulted, `fault_pd_en` falls once the captured flag has been low for RELEASE_CYC consecutive edges (2500 by default), and not earlier.
- R6: An overrange sample captured while the release delay is running restarts that delay from zero.
- R7: With `side_alive` low, `fault_pd_en` is 0 in the same cycle. The fault state and overrange flag are cleared, and samples are ignored.
- R8: Reset (`rst_n` low, asynchronous) forces the not-faulted state with `fault_pd_en` = 0.
- R9: The configuration requires REJECT_CYC <= DETECT_CYC and fails elaboration otherwise. An overrange pulse shorter than REJECT_CYC cycles never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| side_alive | input | 1 | Input side powered and sending |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed current sample |
| thr_mag | input | SAMPLE_W | Unsigned magnitude threshold |
| fault_pd_en | output | 1 | Pull-down enable for the shared active-low fault line |

## Verification
The hardest situation to reach from the ports is the release-restart path. The fault has to be tripped, the input brought back in range, and then a single overrange sample inserted part-way through the release window. The stimulus measures the release from the final in-range sample: if the restart were missing, the line would already have been let go before the checked slot. A second hard case is a long burst of runs one cycle shorter than the detect time, separated by lone in-range samples. After the burst, the enable is checked at a slot that falls before any release could complete. A hidden trip during the burst would therefore still be visible.

// File: rtl/ovr_fault_pkg.sv
`timescale 1ns/1ps
package ovr_fault_pkg;

  typedef enum logic [1:0] {
    FQ_CLEAR     = 2'd0,
    FQ_TRIPPED   = 2'd1,
    FQ_RELEASING = 2'd2
  } fq_state_e;

endpackage

// File: rtl/ovr_mag_cmp.sv
`timescale 1ns/1ps
module ovr_mag_cmp #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       side_alive,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic        [SAMPLE_W-1:0] thr_mag,
  output logic                       ovr_q
);

  logic [SAMPLE_W-1:0] mag;
  logic                over_now;
  logic                ovr_d;
  logic                ovr_en;

  // Two's-complement magnitude; the most negative code maps to 2^(W-1).
  always_comb begin
    if (smp_data[SAMPLE_W-1]) mag = ~smp_data + 1'b1;
    else                      mag = smp_data;
    over_now = (mag > thr_mag);
  end

  always_comb begin
    ovr_en = !side_alive || smp_vld;
    ovr_d  = side_alive && over_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (ovr_en) ovr_q <= ovr_d;
  end

endmodule

// File: rtl/ovr_run_timer.sv
`timescale 1ns/1ps
module ovr_run_timer #(
  parameter int LIMIT = 8,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
    hit    = run && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ovr_fault_fsm.sv
`timescale 1ns/1ps
module ovr_fault_fsm
  import ovr_fault_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      side_alive,
  input  logic      ovr_q,
  input  logic      qual_hit,
  input  logic      rel_hit,
  output logic      qual_run,
  output logic      rel_run,
  output fq_state_e state_q
);

  fq_state_e state_d;

  always_comb begin
    qual_run = side_alive && (state_q == FQ_CLEAR) && ovr_q;
    rel_run  = side_alive && (state_q != FQ_CLEAR) && !ovr_q;
  end

  always_comb begin
    state_d = state_q;
    if (!side_alive) begin
      state_d = FQ_CLEAR;
    end else begin
      unique case (state_q)
        FQ_CLEAR:     if (qual_hit) state_d = FQ_TRIPPED;
        FQ_TRIPPED: begin
          if (rel_hit)     state_d = FQ_CLEAR;
          else if (!ovr_q) state_d = FQ_RELEASING;
        end
        FQ_RELEASING: begin
          if (ovr_q)        state_d = FQ_TRIPPED;
          else if (rel_hit) state_d = FQ_CLEAR;
        end
        default:      state_d = FQ_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FQ_CLEAR;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ovr_fault_qual.sv
`timescale 1ns/1ps
module ovr_fault_qual
  import ovr_fault_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int REJECT_CYC  = 250,
  parameter int DETECT_CYC  = 750,
  parameter int RELEASE_CYC = 2500
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       side_alive,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic        [SAMPLE_W-1:0] thr_mag,
  output logic                       fault_pd_en
);

  generate
    if (REJECT_CYC < 1 || RELEASE_CYC < 1 || REJECT_CYC > DETECT_CYC) begin : g_bad_cfg
      $error("ovr_fault_qual: need 1 <= REJECT_CYC <= DETECT_CYC and RELEASE_CYC >= 1");
    end
  endgenerate

  logic      ovr_q;
  logic      qual_run;
  logic      rel_run;
  logic      qual_hit;
  logic      rel_hit;
  fq_state_e state_q;

  ovr_mag_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .side_alive (side_alive),
    .smp_vld    (smp_vld),
    .smp_data   (smp_data),
    .thr_mag    (thr_mag),
    .ovr_q      (ovr_q)
  );

  ovr_run_timer #(.LIMIT(DETECT_CYC)) u_qual_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (qual_run),
    .hit   (qual_hit)
  );

  ovr_run_timer #(.LIMIT(RELEASE_CYC)) u_rel_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (rel_run),
    .hit   (rel_hit)
  );

  ovr_fault_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .side_alive (side_alive),
    .ovr_q      (ovr_q),
    .qual_hit   (qual_hit),
    .rel_hit    (rel_hit),
    .qual_run   (qual_run),
    .rel_run    (rel_run),
    .state_q    (state_q)
  );

  // A dead input side can never hold the shared line low.
  assign fault_pd_en = side_alive && (state_q != FQ_CLEAR);

endmodule

// File: rtl/ovr_fault_qual_chk.sv
`timescale 1ns/1ps
module ovr_fault_qual_chk #(
  parameter int SAMPLE_W    = 16,
  parameter int DETECT_CYC  = 750,
  parameter int RELEASE_CYC = 2500
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       side_alive,
  input logic                       smp_vld,
  input logic signed [SAMPLE_W-1:0] smp_data,
  input logic                       ovr_q,
  input logic                       fault_pd_en
);

  localparam int MAX_LIM = (DETECT_CYC > RELEASE_CYC) ? DETECT_CYC : RELEASE_CYC;
  localparam int RUN_W   = $clog2(MAX_LIM + 2);
  localparam logic [RUN_W-1:0] DET_L = RUN_W'(DETECT_CYC);
  localparam logic [RUN_W-1:0] REL_L = RUN_W'(RELEASE_CYC);
  localparam logic [RUN_W-1:0] SAT   = '1;

  logic [RUN_W-1:0] hot_run;
  logic [RUN_W-1:0] cold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hot_run <= '0;
    else if (!side_alive || !ovr_q)  hot_run <= '0;
    else if (hot_run != SAT)         hot_run <= hot_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cold_run <= '0;
    else if (!side_alive || ovr_q)   cold_run <= '0;
    else if (cold_run != SAT)        cold_run <= cold_run + 1'b1;
  end

  assert_zero_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (side_alive && smp_vld && smp_data == '0) |=> !ovr_q);

  assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (side_alive && !smp_vld) |=> $stable(ovr_q));

  assert_trip_after_detect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_pd_en) |-> (hot_run >= DET_L));

  assert_release_after_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fault_pd_en) && side_alive && $past(side_alive)) |-> (cold_run >= REL_L));

  assert_hold_while_over_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pd_en && ovr_q) |=> (fault_pd_en || !side_alive));

  assert_dead_side_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !side_alive |=> !fault_pd_en);

endmodule

bind ovr_fault_qual ovr_fault_qual_chk #(
  .SAMPLE_W    (SAMPLE_W),
  .DETECT_CYC  (DETECT_CYC),
  .RELEASE_CYC (RELEASE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .side_alive  (side_alive),
  .smp_vld     (smp_vld),
  .smp_data    (smp_data),
  .ovr_q       (ovr_q),
  .fault_pd_en (fault_pd_en)
);

// File: tb/sim_ovr_fault_qual.sv
`timescale 1ns/1ps
module sim_ovr_fault_qual;

  localparam int W   = 16;
  localparam int REJ = 250;
  localparam int DET = 750;
  localparam int REL = 2500;

  logic                clk;
  logic                rst_n;
  logic                side_alive;
  logic                smp_vld;
  logic signed [W-1:0] smp_data;
  logic        [W-1:0] thr_mag;
  logic                fault_pd_en;

  int n_chk;
  int n_bad;
  bit done;

  ovr_fault_qual #(
    .SAMPLE_W(W), .REJECT_CYC(REJ), .DETECT_CYC(DET), .RELEASE_CYC(REL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .side_alive(side_alive), .smp_vld(smp_vld),
    .smp_data(smp_data), .thr_mag(thr_mag), .fault_pd_en(fault_pd_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: fault_pd_en actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic drive(input logic signed [W-1:0] d);
    @(negedge clk);
    smp_vld  = 1'b1;
    smp_data = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      smp_vld = 1'b0;
    end
  endtask

  task automatic settle();
    drive('0);
    idle(REL + 4);
  endtask

  // Over sample at slot 0; trip visible DET+1 slots later.
  task automatic trip(input logic signed [W-1:0] d, input string tag);
    drive(d);
    idle(DET);
    chk(fault_pd_en, 1'b0, {tag, " one edge before detect"});
    idle(1);
    chk(fault_pd_en, 1'b1, {tag, " tripped at detect"});
  endtask

  task automatic t_reset();
    chk(fault_pd_en, 1'b0, "R8 in reset");
  endtask

  task automatic t_equal_thr();
    thr_mag = 16'd1000;
    drive(16'sd1000);
    idle(DET + 4);
    chk(fault_pd_en, 1'b0, "R1 +thr equal not over");
    drive(-16'sd1000);
    idle(DET + 4);
    chk(fault_pd_en, 1'b0, "R1 -thr equal not over");
    settle();
  endtask

  task automatic t_trip_release_pos();
    thr_mag = 16'd1000;
    trip(16'sd1001, "R3 R2 positive");
    drive(16'sd12);
    idle(REL);
    chk(fault_pd_en, 1'b1, "R5 still held at release-1");
    idle(1);
    chk(fault_pd_en, 1'b0, "R5 released at release");
    settle();
  endtask

  task automatic t_trip_neg();
    thr_mag = 16'd1000;
    trip(-16'sd1001, "R1 negative");
    settle();
    chk(fault_pd_en, 1'b0, "R5 negative released");
    thr_mag = 16'd32767;
    trip(16'sh8000, "R1 most negative code");
    settle();
    thr_mag = 16'd1000;
  endtask

  task automatic t_short_pulses();
    drive(16'sd2000);
    idle(REJ - 2);
    drive('0);
    idle(DET + 4);
    chk(fault_pd_en, 1'b0, "R9 pulse shorter than rejection");
    drive(-16'sd2000);
    idle(DET - 2);
    drive('0);
    idle(DET + 4);
    chk(fault_pd_en, 1'b0, "R3 pulse of detect-1 edges");
    for (int i = 0; i < 6; i++) begin
      drive(16'sd3000);
      idle(DET - 2);
      drive('0);
    end
    idle(DET + 4);
    chk(fault_pd_en, 1'b0, "R4 burst does not accumulate");
    settle();
  endtask

  task automatic t_restart();
    trip(16'sd1500, "R6 setup");
    drive('0);
    idle(5);
    drive(16'sd1500);
    drive('0);
    idle(REL);
    chk(fault_pd_en, 1'b1, "R6 release restarted");
    idle(1);
    chk(fault_pd_en, 1'b0, "R6 released after restart");
    settle();
  endtask

  task automatic t_dead_side();
    trip(16'sd1500, "R7 setup");
    @(negedge clk);
    side_alive = 1'b0;
    #1;
    chk(fault_pd_en, 1'b0, "R7 dead side releases at once");
    for (int i = 0; i < DET + 4; i++) drive(16'sd4000);
    chk(fault_pd_en, 1'b0, "R7 samples ignored while dead");
    @(negedge clk);
    smp_vld    = 1'b0;
    side_alive = 1'b1;
    #1;
    chk(fault_pd_en, 1'b0, "R7 state cleared on return");
    idle(DET + 4);
    chk(fault_pd_en, 1'b0, "R7 overrange flag cleared");
    settle();
  endtask

  task automatic t_reset_mid_fault();
    trip(16'sd1500, "R8 setup");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(fault_pd_en, 1'b0, "R8 async reset clears fault");
    @(negedge clk);
    smp_vld = 1'b0;
    rst_n   = 1'b1;
    idle(DET + 4);
    chk(fault_pd_en, 1'b0, "R8 not faulted after reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; side_alive = 1'b1; smp_vld = 1'b0;
    smp_data = '0; thr_mag = 16'd1000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_equal_thr();
    t_trip_release_pos();
    t_trip_neg();
    t_short_pulses();
    t_restart();
    t_dead_side();
    t_reset_mid_fault();
    finish_run();
  end

  initial begin
    #(4 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

endmodule